// File: doc/BRIEF.md
# Run-Time Depth Input FIFO with Sticky Overrun

This block is a small first-in first-out buffer that sits directly behind the input data register of a data path. Its storage depth is chosen while the chip runs, through a 3-bit depth code, from zero entries up to a built-in maximum of four. At depth zero the block is a plain one-stage register from input to output.

The buffer offers its oldest entry at the output without waiting for a read (show-ahead), and a read strobe consumes it. Three status outputs report empty, full and overrun. Overrun is a sticky loss indicator: it rises when a write meets a full buffer and the word is dropped. It stays up until the host samples it with a status-read strobe. When dynamic flush is on, a write into a full buffer pushes out the oldest entry instead of being lost, and overrun is held low.

Top module: `cfg_fifo`

## Requirements
- R1: The depth code selects the capacity. Binary values 0 to 4 give that many entries, and codes 5, 6 and 7 behave exactly like code 4.
- R2: At depth 0, `rd_data` equals the `wr_data` value present at the previous rising clock edge, whatever the strobes do. `empty` is 1, `full` is 0, and `overrun` is never set.
- R3: At a depth above 0, entries leave in write order. While `empty` is 0, `rd_data` shows the oldest entry. A read strobe consumes that entry at the clock edge. A read strobe while `empty` is 1 has no effect.
- R4: At a depth above 0, `empty` is 1 exactly when no entry is stored, and `full` is 1 exactly when the stored count is at least the selected depth. Both reflect the state after the last clock edge.
- R5: A write strobe while `full` is 1, with no read strobe and dynamic flush off, stores nothing. `overrun` reads 1 from the next cycle on.
- R6: Once set, `overrun` stays 1 until a cycle with `stat_rd` high, and it reads 0 after that edge. A new lost write in the same cycle as `stat_rd` keeps it at 1.
- R7: While `flush_dyn` is 1, `overrun` reads 0 and the stored flag is cleared. A write while full then discards the oldest entry and stores the new word.
- R8: A write strobe and a read strobe together while `full` is 1 both succeed. The stored count is unchanged and `overrun` is not set.
- R9: After reset, `empty` is 1, `full` is 0, `overrun` is 0, and at depth 0 `rd_data` is 0.
- R10: If the depth is lowered below the stored count, the stored entries are kept, `full` stays 1 and writes are lost until reads bring the count below the depth. Selecting depth 0 discards all stored entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read strobe, consumes the oldest entry |
| depth_code | input | 3 | Selected depth, 0 to 4, with larger codes treated as 4 |
| flush_dyn | input | 1 | Dynamic flush: a write into a full buffer evicts the oldest entry |
| stat_rd | input | 1 | Host status read, clears overrun |
| rd_data | output | DATA_W | Oldest entry, or the registered input at depth 0 |
| empty | output | 1 | No entry available |
| full | output | 1 | Stored count reached the selected depth |
| overrun | output | 1 | Sticky flag for a lost write |

## Verification
The bench uses the defaults: DATA_W of 10 and MAX_DEPTH of 4. Every depth code from 0 to 7 can therefore be reached, including the clamped codes, and the buffer fills within a handful of cycles. This makes it cheap to drive it into full-and-writing, depth-lowered-below-count and flush-at-full states many times. A long random phase changes the depth code, flush enable and status reads under traffic, so that depth changes with stored data and status reads in the same cycle as a lost write are also covered.

// File: rtl/cfg_fifo_pkg.sv
package cfg_fifo_pkg;

    // Per-cycle decision of the buffer controller
    typedef struct packed {
        logic push;   // store wr_data
        logic pop;    // host read consumes the oldest entry
        logic drop;   // flush evicts the oldest entry
        logic lost;   // write discarded, buffer full
    } fifo_op_t;

    function automatic fifo_op_t decide_op(
        input logic wr,
        input logic rd,
        input logic is_empty,
        input logic is_full,
        input logic flush
    );
        fifo_op_t op;
        op      = '0;
        op.pop  = rd && !is_empty;
        if (wr) begin
            if (!is_full || op.pop) begin
                op.push = 1'b1;
            end else if (flush) begin
                op.push = 1'b1;
                op.drop = 1'b1;
            end else begin
                op.lost = 1'b1;
            end
        end
        return op;
    endfunction

endpackage

// File: rtl/cfg_fifo_depth.sv
module cfg_fifo_depth #(
    parameter int CODE_W    = 3,
    parameter int MAX_DEPTH = 4,
    parameter int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  depth_n
);

    always_comb begin
        if (int'(code) > MAX_DEPTH) begin
            depth_n = CNT_W'(MAX_DEPTH);
        end else begin
            depth_n = CNT_W'(code);
        end
    end

endmodule

// File: rtl/cfg_fifo_store.sv
module cfg_fifo_store #(
    parameter int DATA_W    = 10,
    parameter int MAX_DEPTH = 4,
    parameter int PTR_W     = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] slot_q [MAX_DEPTH];

    for (genvar i = 0; i < MAX_DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == PTR_W'(i))) begin
                slot_q[i] <= wdata;
            end
        end
    end

    assign rdata = slot_q[raddr];

endmodule

// File: rtl/cfg_fifo_ctrl.sv
module cfg_fifo_ctrl
    import cfg_fifo_pkg::*;
#(
    parameter int MAX_DEPTH = 4,
    parameter int CNT_W     = $clog2(MAX_DEPTH + 1),
    parameter int PTR_W     = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             flush,
    input  logic [CNT_W-1:0] depth_n,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic             push,
    output logic             lost,
    output logic             is_off,
    output logic             empty_int,
    output logic             full_int
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(MAX_DEPTH - 1);

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] wptr_q, rptr_q;
    fifo_op_t         op;
    logic             advance;

    assign is_off    = (depth_n == '0);
    assign empty_int = (count_q == '0);
    assign full_int  = !is_off && (count_q >= depth_n);

    always_comb begin
        op = decide_op(wr_en, rd_en, empty_int, full_int, flush);
        if (is_off) begin
            op = '0;
        end
    end

    assign advance = op.pop || op.drop;
    assign push    = op.push;
    assign lost    = op.lost;
    assign wptr    = wptr_q;
    assign rptr    = rptr_q;

    always_ff @(posedge clk) begin
        if (rst || is_off) begin
            count_q <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else begin
            if (op.push) begin
                wptr_q <= ptr_inc(wptr_q);
            end
            if (advance) begin
                rptr_q <= ptr_inc(rptr_q);
            end
            case ({op.push, advance})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(MAX_DEPTH)); // R4
    AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (rst)
        empty_int |-> !advance); // R3
    AST_FULL_SWAP_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!is_off && full_int && op.push && op.pop) |=> (count_q == $past(count_q))); // R8
    AST_OFF_DISCARDS: assert property (@(posedge clk) disable iff (rst)
        is_off |=> (count_q == '0)); // R10

endmodule

// File: rtl/cfg_fifo_ovr.sv
module cfg_fifo_ovr (
    input  logic clk,
    input  logic rst,
    input  logic lost,
    input  logic stat_rd,
    input  logic flush,
    output logic ovr_q
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ovr_q <= 1'b0;
        end else if (lost) begin
            ovr_q <= 1'b1;
        end else if (stat_rd) begin
            ovr_q <= 1'b0;
        end
    end

    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (lost && !flush) |=> ovr_q); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !stat_rd && !flush) |=> ovr_q); // R6
    AST_OVR_FLUSH_CLR: assert property (@(posedge clk) disable iff (rst)
        flush |=> !ovr_q); // R7

endmodule

// File: rtl/cfg_fifo.sv
module cfg_fifo
    import cfg_fifo_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter int MAX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [2:0]        depth_code,
    input  logic              flush_dyn,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              overrun
);

    localparam int CODE_W = 3;
    localparam int CNT_W  = $clog2(MAX_DEPTH + 1);
    localparam int PTR_W  = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;

    logic [CNT_W-1:0]  depth_n;
    logic [PTR_W-1:0]  wptr, rptr;
    logic              push, lost, is_off, empty_int, full_int, ovr_q;
    logic [DATA_W-1:0] store_rdata;
    logic [DATA_W-1:0] pass_q;

    cfg_fifo_depth #(.CODE_W(CODE_W), .MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) u_depth (
        .code    (depth_code),
        .depth_n (depth_n)
    );

    cfg_fifo_ctrl #(.MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .flush     (flush_dyn),
        .depth_n   (depth_n),
        .wptr      (wptr),
        .rptr      (rptr),
        .push      (push),
        .lost      (lost),
        .is_off    (is_off),
        .empty_int (empty_int),
        .full_int  (full_int)
    );

    cfg_fifo_store #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .PTR_W(PTR_W)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (rptr),
        .rdata (store_rdata)
    );

    cfg_fifo_ovr u_ovr (
        .clk     (clk),
        .rst     (rst),
        .lost    (lost),
        .stat_rd (stat_rd),
        .flush   (flush_dyn),
        .ovr_q   (ovr_q)
    );

    // Single input stage used as the whole path at depth 0
    always_ff @(posedge clk) begin
        if (rst) begin
            pass_q <= '0;
        end else begin
            pass_q <= wr_data;
        end
    end

    assign rd_data = is_off ? pass_q : store_rdata;
    assign empty   = is_off || empty_int;
    assign full    = full_int;
    assign overrun = ovr_q && !flush_dyn;

    AST_OFF_NEVER_FULL: assert property (@(posedge clk) disable iff (rst)
        (depth_code == 3'd0) |-> (empty && !full)); // R2

endmodule

// File: tb/test_cfg_fifo.sv
module test_cfg_fifo;

    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0, flush_dyn = 1'b0, stat_rd = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [2:0]    depth_code = 3'd0;
    logic [DW-1:0] rd_data;
    logic          empty, full, overrun;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [DW-1:0] mq[$];
    logic [DW-1:0] m_pass = '0;
    bit            m_ovr  = 1'b0;

    always #4 clk = ~clk;

    cfg_fifo #(.DATA_W(DW), .MAX_DEPTH(4)) i_cfg_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .depth_code(depth_code), .flush_dyn(flush_dyn), .stat_rd(stat_rd),
        .rd_data(rd_data), .empty(empty), .full(full), .overrun(overrun)
    );

    function automatic int cap(input logic [2:0] c);
        return (c > 3'd4) ? 4 : int'(c);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        int  d;
        bit  e_empty, e_full, e_ovr;
        d       = cap(depth_code);
        e_empty = (d == 0) || (mq.size() == 0);
        e_full  = (d != 0) && (mq.size() >= d);
        e_ovr   = m_ovr && !flush_dyn;
        chk(empty == e_empty, {tag, " R4 empty"}, int'(empty), int'(e_empty));
        chk(full == e_full, {tag, " R4 full"}, int'(full), int'(e_full));
        chk(overrun == e_ovr, {tag, " R6 overrun"}, int'(overrun), int'(e_ovr));
        if (d == 0) begin
            chk(rd_data == m_pass, {tag, " R2 pass data"}, int'(rd_data), int'(m_pass));
        end else if (mq.size() != 0) begin
            chk(rd_data == mq[0], {tag, " R3 head data"}, int'(rd_data), int'(mq[0]));
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, check at the next falling edge
    task automatic step(input bit w, input logic [DW-1:0] dat, input bit r,
                        input logic [2:0] c, input bit f, input bit s, input string tag);
        int d;
        bit is_full, pop, lost;
        wr_en = w; wr_data = dat; rd_en = r; depth_code = c; flush_dyn = f; stat_rd = s;
        d    = cap(c);
        lost = 1'b0;
        if (d == 0) begin
            mq.delete();
        end else begin
            is_full = mq.size() >= d;
            pop     = r && (mq.size() != 0);
            if (pop) void'(mq.pop_front());
            if (w) begin
                if (!is_full || pop) begin
                    mq.push_back(dat);
                end else if (f) begin
                    void'(mq.pop_front());
                    mq.push_back(dat);
                end else begin
                    lost = 1'b1;
                end
            end
        end
        m_pass = dat;
        if (f) m_ovr = 1'b0;
        else if (lost) m_ovr = 1'b1;
        else if (s) m_ovr = 1'b0;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk(empty == 1'b1, "R9 empty", int'(empty), 1);
        chk(full == 1'b0, "R9 full", int'(full), 0);
        chk(overrun == 1'b0, "R9 overrun", int'(overrun), 0);
        chk(rd_data == '0, "R9 rd_data", int'(rd_data), 0);

        // R3/R4: depth 3, fill in order
        step(1, 10'h101, 0, 3'd3, 0, 0, "R3 fill");
        step(1, 10'h102, 0, 3'd3, 0, 0, "R3 fill");
        step(1, 10'h103, 0, 3'd3, 0, 0, "R4 full");
        // R5: write while full is lost
        step(1, 10'h1FF, 0, 3'd3, 0, 0, "R5 lost write");
        chk(overrun == 1'b1, "R5 overrun set", int'(overrun), 1);
        // R6: sticky, then cleared by status read
        step(0, 10'h000, 0, 3'd3, 0, 0, "R6 hold");
        step(0, 10'h000, 0, 3'd3, 0, 1, "R6 clear");
        chk(overrun == 1'b0, "R6 cleared", int'(overrun), 0);
        // R6: lost write in the same cycle as the status read keeps the flag
        step(1, 10'h1EE, 0, 3'd3, 0, 1, "R6 set wins");
        chk(overrun == 1'b1, "R6 set wins", int'(overrun), 1);
        // R8: simultaneous read and write while full
        step(1, 10'h104, 1, 3'd3, 0, 1, "R8 swap at full");
        chk(full == 1'b1, "R8 still full", int'(full), 1);
        chk(overrun == 1'b0, "R8 no overrun", int'(overrun), 0);
        // R7: flush evicts oldest and masks overrun
        step(1, 10'h1AA, 0, 3'd3, 0, 0, "R7 prep lost");
        step(0, 10'h000, 0, 3'd3, 1, 0, "R7 mask");
        chk(overrun == 1'b0, "R7 masked", int'(overrun), 0);
        step(1, 10'h105, 0, 3'd3, 1, 0, "R7 evict");
        step(0, 10'h000, 0, 3'd3, 0, 0, "R7 after flush");
        chk(overrun == 1'b0, "R7 flag cleared", int'(overrun), 0);
        // R3: drain and read while empty
        for (int i = 0; i < 5; i++) step(0, 10'h000, 1, 3'd3, 0, 0, "R3 drain");
        chk(empty == 1'b1, "R3 empty after drain", int'(empty), 1);
        // R1: clamped codes behave as depth 4
        for (int i = 0; i < 5; i++) step(1, 10'h200 + DW'(i), 0, 3'd5, 0, 0, "R1 code5");
        chk(full == 1'b1, "R1 code5 full at 4", int'(full), 1);
        for (int i = 0; i < 4; i++) step(0, 10'h000, 1, 3'd7, 0, 1, "R1 code7 drain");
        // R10: lower depth below count
        for (int i = 0; i < 4; i++) step(1, 10'h300 + DW'(i), 0, 3'd4, 0, 0, "R10 fill");
        step(1, 10'h3F0, 0, 3'd2, 0, 0, "R10 lowered");
        step(0, 10'h000, 1, 3'd2, 0, 1, "R10 read");
        step(1, 10'h3F1, 0, 3'd2, 0, 0, "R10 still full");
        step(0, 10'h000, 1, 3'd2, 0, 0, "R10 read");
        step(0, 10'h000, 1, 3'd2, 0, 0, "R10 read");
        step(1, 10'h3F2, 0, 3'd2, 0, 1, "R10 accepted");
        // R2/R10: depth 0 discards and passes through
        step(1, 10'h055, 0, 3'd0, 0, 0, "R10 discard");
        step(0, 10'h0AA, 1, 3'd0, 0, 0, "R2 pass");
        step(1, 10'h133, 1, 3'd0, 0, 1, "R2 pass");
        step(0, 10'h000, 0, 3'd1, 0, 0, "R10 reopen empty");
        chk(empty == 1'b1, "R10 reopened empty", int'(empty), 1);
        // Random traffic across all codes
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] c;
            c = (($urandom % 16) == 0) ? 3'($urandom) : depth_code;
            step(1'($urandom), DW'($urandom), 1'($urandom), c,
                 (($urandom % 8) == 0), (($urandom % 6) == 0), "R1 random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule